// File: doc/BRIEF.md
# Trim Byte Indirect Access Port

This block holds run-time working copies of a bank of analog trim bytes and gives software an indirect path to them. Software first writes an entry index to the index register. A read of the value register then returns the working byte at that index, and a write to the value register replaces it. All working bytes leave the block together on one flat vector that feeds the analog circuits. A value written there reaches that vector on the clock edge that accepts the write.

The working copies start from a factory image that lies in a fixed window of the nonvolatile information page. The window begins at page address 0x20, and entry k sits at page address 0x20 + k. A separate loader fetches that image at reset and pulses `load_req` when it is done. The same pulse, given again later, restores the factory values. Writes through the port change only the working copy. They never reach nonvolatile storage, so losing power or erasing program memory leaves the factory values in place.

A two-state controller sequences the block. `ST_WAIT_LOAD` is the state after reset, and value writes are ignored in it. A `load_req` pulse moves the controller to `ST_READY` (transition "load done"). Another `load_req` in `ST_READY` keeps it in `ST_READY` (transition "reload") and copies the image again.

Top module: `trim_port`

## Requirements
- R1: After reset, the index is 0, every working byte is 0x00, and the controller is in ST_WAIT_LOAD.
- R2: A `load_req` pulse copies `nv_image` into all working bytes on the next clock edge. Entry k occupies bits [8k+7:8k]. The controller enters ST_READY.
- R3: A write with `bus_reg`=0 (index register) stores the low 5 bits of `bus_wdata`. A read of the index register returns those bits with the upper 3 bits as zero.
- R4: In ST_READY, a write with `bus_reg`=1 (value register) replaces only the working byte selected by the index. The new value appears on `trim_flat` after that clock edge.
- R5: With `bus_reg`=1, `bus_rdata` gives the current working byte at the index combinationally.
- R6: Value writes in ST_WAIT_LOAD leave every working byte unchanged.
- R7: The index keeps its value across value-register reads and writes. Only an index-register write changes it.
- R8: `info_addr` equals 0x20 plus the index, so it always lies in the range 0x20 to 0x3F.
- R9: A `load_req` pulse in ST_READY restores every factory value over earlier overrides. It takes priority over a value write in the same cycle.
- R10: A change of `nv_image` without a `load_req` pulse has no effect on the working bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_req | input | 1 | Single-cycle pulse: factory image on `nv_image` is valid, copy it |
| nv_image | input | 256 | Factory trim image, entry k at bits [8k+7:8k] |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 1 | 0 = index register, 1 = value register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| info_addr | output | 6 | Information-page address of the selected entry |
| trim_flat | output | 256 | All working trim bytes, entry k at bits [8k+7:8k] |

## Verification
The bench builds the block with its default parameters: 32 entries of 8 bits and an information window that starts at 0x20. With that build the index reaches both ends of the window, 0 and 31, so the bench can see `info_addr` at 0x20 and 0x3F. The 8-bit data path lets an index write with upper bits set show that those bits are dropped on readback. A full sweep that writes and reads all 32 entries shows that no write reaches a neighbouring byte.

// File: rtl/trim_port_pkg.sv
package trim_port_pkg;

    typedef enum logic {
        ST_WAIT_LOAD = 1'b0,
        ST_READY     = 1'b1
    } trim_state_e;

    typedef enum logic {
        REG_INDEX = 1'b0,
        REG_VALUE = 1'b1
    } trim_reg_e;

endpackage

// File: rtl/trim_index_reg.sv
module trim_index_reg #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  idx
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (wr_en) begin
            idx <= wdata[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/trim_bank.sv
module trim_bank #(
    parameter int NUM    = 32,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_en,
    input  logic [NUM*DATA_W-1:0] nv_image,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [DATA_W-1:0]     wdata,
    output logic [NUM*DATA_W-1:0] bank_flat
);

    genvar g;
    generate
        for (g = 0; g < NUM; g++) begin : g_entry
            logic [DATA_W-1:0] entry_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    entry_q <= '0;
                end else if (load_en) begin
                    entry_q <= nv_image[g*DATA_W +: DATA_W];
                end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                    entry_q <= wdata;
                end
            end
            assign bank_flat[g*DATA_W +: DATA_W] = entry_q;
        end
    endgenerate

endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl
    import trim_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_req,
    input  logic        bus_en,
    input  logic        bus_wr,
    input  logic        bus_reg,
    output logic        idx_we,
    output logic        val_we,
    output logic        load_en,
    output trim_state_e state
);

    trim_state_e state_nx;
    logic        wr_strobe;

    assign wr_strobe = bus_en && bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT_LOAD;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        idx_we   = wr_strobe && (trim_reg_e'(bus_reg) == REG_INDEX);
        val_we   = 1'b0;
        load_en  = load_req;
        unique case (state)
            ST_WAIT_LOAD: begin
                if (load_req) begin
                    state_nx = ST_READY;
                end
            end
            ST_READY: begin
                state_nx = ST_READY;
                val_we   = wr_strobe && (trim_reg_e'(bus_reg) == REG_VALUE) && !load_req;
            end
            default: state_nx = ST_WAIT_LOAD;
        endcase
    end

endmodule

// File: rtl/trim_port.sv
module trim_port #(
    parameter int NUM       = 32,
    parameter int DATA_W    = 8,
    parameter int INFO_AW   = 6,
    parameter int INFO_BASE = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_req,
    input  logic [NUM*DATA_W-1:0] nv_image,
    input  logic                  bus_en,
    input  logic                  bus_wr,
    input  logic                  bus_reg,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [INFO_AW-1:0]    info_addr,
    output logic [NUM*DATA_W-1:0] trim_flat
);
    import trim_port_pkg::*;

    localparam int IDX_W = $clog2(NUM);

    logic                 idx_we;
    logic                 val_we;
    logic                 load_en;
    trim_state_e          state;
    logic [IDX_W-1:0]     idx_q;
    logic [DATA_W-1:0]    bank_arr [NUM];

    trim_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (load_req),
        .bus_en   (bus_en),
        .bus_wr   (bus_wr),
        .bus_reg  (bus_reg),
        .idx_we   (idx_we),
        .val_we   (val_we),
        .load_en  (load_en),
        .state    (state)
    );

    trim_index_reg #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (idx_we),
        .wdata (bus_wdata),
        .idx   (idx_q)
    );

    trim_bank #(.NUM(NUM), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .nv_image  (nv_image),
        .wr_en     (val_we),
        .wr_idx    (idx_q),
        .wdata     (bus_wdata),
        .bank_flat (trim_flat)
    );

    genvar g;
    generate
        for (g = 0; g < NUM; g++) begin : g_view
            assign bank_arr[g] = trim_flat[g*DATA_W +: DATA_W];
        end
    endgenerate

    always_comb begin
        if (trim_reg_e'(bus_reg) == REG_VALUE) begin
            bus_rdata = bank_arr[idx_q];
        end else begin
            bus_rdata = {{(DATA_W-IDX_W){1'b0}}, idx_q};
        end
    end

    assign info_addr = INFO_AW'(INFO_BASE) + INFO_AW'(idx_q);

endmodule

// File: rtl/trim_port_chk.sv
module trim_port_chk
    import trim_port_pkg::*;
#(
    parameter int NUM       = 32,
    parameter int DATA_W    = 8,
    parameter int INFO_AW   = 6,
    parameter int INFO_BASE = 32,
    parameter int IDX_W     = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  load_req,
    input logic [NUM*DATA_W-1:0] nv_image,
    input logic                  bus_en,
    input logic                  bus_wr,
    input logic                  bus_reg,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [INFO_AW-1:0]    info_addr,
    input logic [NUM*DATA_W-1:0] trim_flat,
    input logic [IDX_W-1:0]      idx,
    input trim_state_e           state
);

    // R2, R9: a load pulse lands the factory image on the next edge
    p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> trim_flat == $past(nv_image));

    // R10: no load and no write keeps the working bytes
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_req && !(bus_en && bus_wr)) |=> $stable(trim_flat));

    // R6: waiting for the image, value writes change nothing
    p_wait_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_LOAD && !load_req) |=> $stable(trim_flat));

    // R7: index changes only on an index-register write
    p_idx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_wr && bus_reg == 1'b0) |=> $stable(idx));

    // R3: index readback has zero upper bits
    p_idx_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reg == 1'b0) |-> (bus_rdata >> IDX_W) == '0);

    // R8: page address stays inside the trim window
    p_info_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (info_addr >= INFO_AW'(INFO_BASE)) && (32'(info_addr) < INFO_BASE + NUM));

endmodule

bind trim_port trim_port_chk #(
    .NUM(NUM), .DATA_W(DATA_W), .INFO_AW(INFO_AW), .INFO_BASE(INFO_BASE), .IDX_W(IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (load_req),
    .nv_image  (nv_image),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_reg   (bus_reg),
    .bus_rdata (bus_rdata),
    .info_addr (info_addr),
    .trim_flat (trim_flat),
    .idx       (idx_q),
    .state     (state)
);

// File: tb/test_trim_port.sv
`timescale 1ns/1ps
module test_trim_port;

    localparam int NUM = 32;
    localparam int W   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load_req = 1'b0;
    logic [NUM*W-1:0] nv_image = '0;
    logic            bus_en = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_reg = 1'b0;
    logic [W-1:0]    bus_wdata = '0;
    logic [W-1:0]    bus_rdata;
    logic [5:0]      info_addr;
    logic [NUM*W-1:0] trim_flat;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] model [NUM];

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } sb_item_t;
    sb_item_t sb_q [$];

    always #10 clk = ~clk;

    trim_port i_trim_port (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .nv_image(nv_image),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_reg(bus_reg), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .info_addr(info_addr), .trim_flat(trim_flat)
    );

    task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data at the falling edge
    always @(negedge clk) begin
        if (rst_n && bus_en && !bus_wr && sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(bus_rdata == it.exp, it.tag, 256'(bus_rdata), 256'(it.exp));
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        bus_en = 1'b0; bus_wr = 1'b0; load_req = 1'b0;
    endtask

    task automatic wr_reg(input logic r, input logic [W-1:0] d);
        bus_en = 1'b1; bus_wr = 1'b1; bus_reg = r; bus_wdata = d;
        step();
        idle();
    endtask

    task automatic rd_reg(input logic r, input logic [W-1:0] exp, input string tag);
        sb_item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        bus_en = 1'b1; bus_wr = 1'b0; bus_reg = r;
        step();
        idle();
    endtask

    task automatic pulse_load();
        load_req = 1'b1;
        step();
        idle();
    endtask

    task automatic check_bank(input string tag);
        logic [NUM*W-1:0] e;
        for (int k = 0; k < NUM; k++) e[k*W +: W] = model[k];
        check(trim_flat == e, tag, trim_flat, e);
    endtask

    initial begin
        for (int k = 0; k < NUM; k++) model[k] = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        step();

        // R1: reset state
        check_bank("R1 bank zero after reset");
        rd_reg(1'b0, 8'h00, "R1 index zero after reset");
        check(info_addr == 6'h20, "R1 info_addr at reset", 256'(info_addr), 256'(6'h20));

        // R6: value write before load ignored
        wr_reg(1'b0, 8'h03);
        wr_reg(1'b1, 8'hAB);
        check_bank("R6 write before load ignored");
        rd_reg(1'b1, 8'h00, "R6 read before load");

        // R2: load factory image
        for (int k = 0; k < NUM; k++) begin
            nv_image[k*W +: W] = 8'((k * 37 + 5) & 8'hFF);
            model[k] = 8'((k * 37 + 5) & 8'hFF);
        end
        pulse_load();
        check_bank("R2 factory image copied");

        // R10: image change without load
        nv_image = ~nv_image;
        step();
        check_bank("R10 image change without load");

        // R3, R8: index write with upper bits set
        wr_reg(1'b0, 8'hE7);
        rd_reg(1'b0, 8'h07, "R3 index readback upper bits zero");
        check(info_addr == 6'h27, "R8 info_addr for index 7", 256'(info_addr), 256'(6'h27));

        // R5: value read
        rd_reg(1'b1, model[7], "R5 read selected byte");

        // R4: value write only touches the selected byte
        wr_reg(1'b1, 8'h5A);
        model[7] = 8'h5A;
        check_bank("R4 single byte updated");

        // R7: index held across value accesses
        rd_reg(1'b0, 8'h07, "R7 index held after value write");
        rd_reg(1'b1, 8'h5A, "R5 readback of written byte");

        // R4, R5 sweep over every entry
        for (int k = 0; k < NUM; k++) begin
            wr_reg(1'b0, 8'(k));
            wr_reg(1'b1, 8'(k) ^ 8'hC3);
            model[k] = 8'(k) ^ 8'hC3;
        end
        check_bank("R4 sweep bank contents");
        for (int k = 0; k < NUM; k++) begin
            wr_reg(1'b0, 8'(k));
            rd_reg(1'b1, 8'(k) ^ 8'hC3, "R5 sweep readback");
        end
        check(info_addr == 6'h3F, "R8 info_addr top of window", 256'(info_addr), 256'(6'h3F));
        rd_reg(1'b0, 8'h1F, "R7 index held after sweep reads");

        // R9: reload wins over simultaneous value write
        for (int k = 0; k < NUM; k++) model[k] = nv_image[k*W +: W];
        bus_en = 1'b1; bus_wr = 1'b1; bus_reg = 1'b1; bus_wdata = 8'h11;
        load_req = 1'b1;
        step();
        idle();
        check_bank("R9 reload restores factory over write");

        step();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule